// File: doc/BRIEF.md
# Flash Command Sequencer with Operation Status

This block is the command state machine in front of a byte-wide flash array. It watches decoded write cycles, each an address and a data byte. When the cycles form a valid unlock-and-command sequence, it launches one of four embedded operations: byte program, 4 KB sector erase, 64 KB block erase or whole-chip erase. A launch raises a one-cycle request to the array, carrying the operation kind, the inclusive address range and the byte to write. The array side carries out the request. A program request may only clear bits, so the array merges the new byte into the stored one with a bitwise AND.

The cell timing is modelled by a down-counter. Each operation kind has its own parameterised length. While the counter runs, the block reports busy and drops every write cycle. Reads taken during that time return a status byte instead of array data. Bit 7 carries the inverse of the bit 7 the operation will leave behind. Bit 6 flips on every status read. Once the counter expires, the block is back in read-array mode, and reads pass the array byte through unchanged.

Top module: `flash_cmd_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `op_req` and `rd_valid` are 0, `rd_data` is 00h, and the sequencer waits for a first unlock cycle.
- R2: A program runs on the writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by data D at address P. The unlock addresses are compared on the low UNLOCK_W (15) address bits only. In the cycle after the write carrying D, `op_req` is 1 with `op_kind`=0, `op_lo`=`op_hi`=P and `op_data`=D.
- R3: A sector erase runs on the writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh, then 30h at address S. The request has `op_kind`=1, `op_data`=FFh, and a range equal to the 4 KB-aligned span that contains S.
- R4: The same five-cycle prefix followed by 50h at address B gives `op_kind`=2. The range is the 64 KB-aligned span that contains B.
- R5: The same prefix followed by 10h at 5555h gives `op_kind`=3 over the range 0 to the top address. 10h at any other address launches nothing.
- R6: A write whose data or address does not match the expected next cycle returns the sequencer to idle. That write is discarded and is not taken as a new first cycle.
- R7: `busy` rises in the same cycle as `op_req` and stays high for exactly PROG_CYC, SECT_CYC, BLK_CYC or CHIP_CYC cycles, according to the kind. `op_req` lasts one cycle.
- R8: Every write sampled while `busy` is 1 is ignored, and no partial sequence survives the operation.
- R9: A read strobe gives `rd_valid` one cycle later. When `busy` was 0 at the strobe, `rd_data` is the `arr_rdata` byte presented with the strobe.
- R10: When `busy` was 1 at the strobe, `rd_data[7]` is the inverse of bit 7 of the expected final byte, and `rd_data[5:0]` is 0. The expected final byte is the programmed data for a program and FFh for any erase.
- R11: `rd_data[6]` is 0 on the first status read after a launch, and it inverts on every further status read.
- R12: Once `busy` has fallen, reads return array data again, so bit 6 no longer toggles.
- R13: A reset in the middle of an operation clears `busy` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Decoded write cycle strobe |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | 8 | Write cycle data |
| rd_en | input | 1 | Read strobe |
| arr_rdata | input | 8 | Array byte at the read address, presented with `rd_en` |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_en` |
| rd_data | output | 8 | Array data or status byte |
| op_req | output | 1 | One-cycle launch request to the array |
| op_kind | output | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| op_lo | output | ADDR_W | First address of the target range |
| op_hi | output | ADDR_W | Last address of the target range |
| op_data | output | 8 | Byte to write (FFh for erases) |
| busy | output | 1 | Embedded operation in progress |

## Verification
Two events can meet in one cycle: the last counted cycle of an operation, and a host access. The bench waits until it has seen `busy` high for exactly the operation length and then issues the access in that cycle. A read issued there must still return the status byte, and the next read must return array data. In a second case, an unlock write placed in that final cycle must be dropped. The bench confirms this by completing the rest of a program sequence afterwards and expecting no request.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    OPK_PROG = 2'd0,
    OPK_SECT = 2'd1,
    OPK_BLK  = 2'd2,
    OPK_CHIP = 2'd3
  } op_kind_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PROG,
    SQ_ERS3,
    SQ_ERS4,
    SQ_ERS5
  } seq_state_t;

  localparam logic [7:0] CODE_UNL_A   = 8'hAA;
  localparam logic [7:0] CODE_UNL_B   = 8'h55;
  localparam logic [7:0] CODE_PROG    = 8'hA0;
  localparam logic [7:0] CODE_ERSETUP = 8'h80;
  localparam logic [7:0] CODE_SECT    = 8'h30;
  localparam logic [7:0] CODE_BLK     = 8'h50;
  localparam logic [7:0] CODE_CHIP    = 8'h10;

  localparam logic [15:0] ADR_UNL_A = 16'h5555;
  localparam logic [15:0] ADR_UNL_B = 16'h2AAA;
endpackage

// File: rtl/fcs_cmd_decode.sv
module fcs_cmd_decode
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int UNLOCK_W = 15,
  parameter int SECT_W   = 12,
  parameter int BLK_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                busy,
  output logic                launch,
  output op_kind_t            launch_kind,
  output logic                launch_bit7,
  output logic                op_req,
  output op_kind_t            op_kind,
  output logic [ADDR_W-1:0]   op_lo,
  output logic [ADDR_W-1:0]   op_hi,
  output logic [DATA_W-1:0]   op_data
);
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((64'd1 << SECT_W) - 64'd1);
  localparam logic [ADDR_W-1:0] BLK_MASK  = ADDR_W'((64'd1 << BLK_W) - 64'd1);

  seq_state_t state, nxt;
  logic hit_a, hit_b;
  logic [ADDR_W-1:0] lo_c, hi_c;

  assign hit_a = (wr_addr[UNLOCK_W-1:0] == ADR_UNL_A[UNLOCK_W-1:0]);
  assign hit_b = (wr_addr[UNLOCK_W-1:0] == ADR_UNL_B[UNLOCK_W-1:0]);

  always_comb begin
    nxt         = state;
    launch      = 1'b0;
    launch_kind = OPK_PROG;
    if (busy) begin
      nxt = SQ_IDLE;
    end else if (wr_en) begin
      unique case (state)
        SQ_IDLE: nxt = (wr_data == CODE_UNL_A && hit_a) ? SQ_UNL1 : SQ_IDLE;
        SQ_UNL1: nxt = (wr_data == CODE_UNL_B && hit_b) ? SQ_UNL2 : SQ_IDLE;
        SQ_UNL2: begin
          if (wr_data == CODE_PROG && hit_a)         nxt = SQ_PROG;
          else if (wr_data == CODE_ERSETUP && hit_a) nxt = SQ_ERS3;
          else                                       nxt = SQ_IDLE;
        end
        SQ_PROG: begin
          launch      = 1'b1;
          launch_kind = OPK_PROG;
          nxt         = SQ_IDLE;
        end
        SQ_ERS3: nxt = (wr_data == CODE_UNL_A && hit_a) ? SQ_ERS4 : SQ_IDLE;
        SQ_ERS4: nxt = (wr_data == CODE_UNL_B && hit_b) ? SQ_ERS5 : SQ_IDLE;
        SQ_ERS5: begin
          nxt = SQ_IDLE;
          if (wr_data == CODE_SECT) begin
            launch = 1'b1; launch_kind = OPK_SECT;
          end else if (wr_data == CODE_BLK) begin
            launch = 1'b1; launch_kind = OPK_BLK;
          end else if (wr_data == CODE_CHIP && hit_a) begin
            launch = 1'b1; launch_kind = OPK_CHIP;
          end
        end
        default: nxt = SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (launch_kind)
      OPK_SECT: begin lo_c = wr_addr & ~SECT_MASK; hi_c = wr_addr | SECT_MASK; end
      OPK_BLK:  begin lo_c = wr_addr & ~BLK_MASK;  hi_c = wr_addr | BLK_MASK;  end
      OPK_CHIP: begin lo_c = '0;                   hi_c = '1;                  end
      default:  begin lo_c = wr_addr;              hi_c = wr_addr;             end
    endcase
  end

  assign launch_bit7 = (launch_kind == OPK_PROG) ? wr_data[7] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      op_req  <= 1'b0;
      op_kind <= OPK_PROG;
      op_lo   <= '0;
      op_hi   <= '0;
      op_data <= '0;
    end else begin
      state  <= nxt;
      op_req <= launch;
      if (launch) begin
        op_kind <= launch_kind;
        op_lo   <= lo_c;
        op_hi   <= hi_c;
        op_data <= (launch_kind == OPK_PROG) ? wr_data : 8'hFF;
      end
    end
  end

  // A launch may only come from a cycle in which no operation was running.
  assert_no_launch_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
    op_req |-> !$past(busy))
    else $error("launch accepted while busy");

  assert_req_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    op_req |=> !op_req)
    else $error("request longer than one cycle");

  assert_range_ordered_R3: assert property (@(posedge clk) disable iff (rst)
    op_req |-> (op_lo <= op_hi))
    else $error("target range reversed");
endmodule

// File: rtl/fcs_op_timer.sv
module fcs_op_timer
  import flash_seq_pkg::*;
#(
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 200,
  parameter int BLK_CYC  = 400,
  parameter int CHIP_CYC = 800,
  parameter int CNT_W    = 10
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  op_kind_t kind,
  output logic     busy
);
  logic [CNT_W-1:0] cnt, dur;

  always_comb begin
    unique case (kind)
      OPK_SECT: dur = CNT_W'(SECT_CYC - 1);
      OPK_BLK:  dur = CNT_W'(BLK_CYC - 1);
      OPK_CHIP: dur = CNT_W'(CHIP_CYC - 1);
      default:  dur = CNT_W'(PROG_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= dur;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assert_busy_needs_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start))
    else $error("busy rose without launch");

  assert_count_steps_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (cnt == CNT_W'($past(cnt) - 1'b1)))
    else $error("counter skipped");

  assert_end_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(cnt) == '0 || $past(rst)))
    else $error("busy ended early");
endmodule

// File: rtl/fcs_status_read.sv
module fcs_status_read
  import flash_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_bit7,
  input  logic              busy,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic tog, exp7;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      tog      <= 1'b0;
      exp7     <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (start) begin
        exp7 <= start_bit7;
        tog  <= 1'b0;
      end
      if (rd_en) begin
        if (busy) begin
          rd_data <= {~exp7, tog, 6'b0};
          tog     <= ~tog;
        end else begin
          rd_data <= arr_rdata;
        end
      end
    end
  end

  assert_status_low_bits_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(busy)) |-> (rd_data[5:0] == 6'b0))
    else $error("status low bits not clear");

  assert_idle_passthru_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !$past(busy)) |-> (rd_data == $past(arr_rdata)))
    else $error("idle read not array data");
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int UNLOCK_W = 15,
  parameter int SECT_W   = 12,
  parameter int BLK_W    = 16,
  parameter int PROG_CYC = 20,
  parameter int SECT_CYC = 200,
  parameter int BLK_CYC  = 400,
  parameter int CHIP_CYC = 800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [7:0]        arr_rdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              op_req,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_lo,
  output logic [ADDR_W-1:0] op_hi,
  output logic [7:0]        op_data,
  output logic              busy
);
  localparam int MAX_A   = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_B   = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic     launch, launch_bit7;
  op_kind_t launch_kind, kind_q;

  fcs_cmd_decode #(
    .ADDR_W(ADDR_W), .UNLOCK_W(UNLOCK_W), .SECT_W(SECT_W), .BLK_W(BLK_W)
  ) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .launch(launch), .launch_kind(launch_kind),
    .launch_bit7(launch_bit7), .op_req(op_req), .op_kind(kind_q),
    .op_lo(op_lo), .op_hi(op_hi), .op_data(op_data)
  );

  fcs_op_timer #(
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .BLK_CYC(BLK_CYC),
    .CHIP_CYC(CHIP_CYC), .CNT_W(CNT_W)
  ) u_tmr (
    .clk(clk), .rst(rst), .start(launch), .kind(launch_kind), .busy(busy)
  );

  fcs_status_read u_sts (
    .clk(clk), .rst(rst), .start(launch), .start_bit7(launch_bit7),
    .busy(busy), .rd_en(rd_en), .arr_rdata(arr_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign op_kind = kind_q;

  assert_req_with_busy_R7: assert property (@(posedge clk) disable iff (rst)
    op_req |-> busy)
    else $error("request without busy");
endmodule

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int P_CYC = 4, S_CYC = 6, B_CYC = 8, C_CYC = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          rd_en = 1'b0;
  logic [7:0]    arr_rdata = '0;
  logic          rd_valid, op_req, busy;
  logic [7:0]    rd_data, op_data;
  logic [1:0]    op_kind;
  logic [AW-1:0] op_lo, op_hi;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(
    .ADDR_W(AW), .PROG_CYC(P_CYC), .SECT_CYC(S_CYC), .BLK_CYC(B_CYC), .CHIP_CYC(C_CYC)
  ) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .arr_rdata(arr_rdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .op_req(op_req), .op_kind(op_kind), .op_lo(op_lo), .op_hi(op_hi),
    .op_data(op_data), .busy(busy)
  );

  // {expect request, kind, address, data}
  localparam int NV = 44;
  localparam logic [29:0] VEC [NV] = '{
    {1'b0,2'd0,19'h05555,8'hAA}, {1'b0,2'd0,19'h02AAA,8'h55},
    {1'b0,2'd0,19'h05555,8'hA0}, {1'b1,2'd0,19'h01234,8'h3C},
    {1'b0,2'd0,19'h05555,8'hAA}, {1'b0,2'd0,19'h02AAA,8'h55},
    {1'b0,2'd0,19'h05555,8'h80}, {1'b0,2'd0,19'h05555,8'hAA},
    {1'b0,2'd0,19'h02AAA,8'h55}, {1'b1,2'd1,19'h23456,8'h30},
    {1'b0,2'd0,19'h05555,8'hAA}, {1'b0,2'd0,19'h02AAA,8'h55},
    {1'b0,2'd0,19'h05555,8'h80}, {1'b0,2'd0,19'h05555,8'hAA},
    {1'b0,2'd0,19'h02AAA,8'h55}, {1'b1,2'd2,19'h4ABCD,8'h50},
    {1'b0,2'd0,19'h05555,8'hAA}, {1'b0,2'd0,19'h02AAA,8'h55},
    {1'b0,2'd0,19'h05555,8'h80}, {1'b0,2'd0,19'h05555,8'hAA},
    {1'b0,2'd0,19'h02AAA,8'h55}, {1'b1,2'd3,19'h05555,8'h10},
    {1'b0,2'd0,19'h05555,8'hAA}, {1'b0,2'd0,19'h01234,8'h55},
    {1'b0,2'd0,19'h02AAA,8'h55}, {1'b0,2'd0,19'h05555,8'hA0},
    {1'b0,2'd0,19'h00100,8'h77},
    {1'b0,2'd0,19'h05555,8'hAA}, {1'b0,2'd0,19'h02AAA,8'h55},
    {1'b0,2'd0,19'h05555,8'h80}, {1'b0,2'd0,19'h05555,8'hAA},
    {1'b0,2'd0,19'h02AAA,8'h55}, {1'b0,2'd0,19'h00100,8'h20},
    {1'b0,2'd0,19'h00100,8'h40},
    {1'b0,2'd0,19'h45555,8'hAA}, {1'b0,2'd0,19'h7AAAA,8'h55},
    {1'b0,2'd0,19'h75555,8'hA0}, {1'b1,2'd0,19'h7FFFF,8'h81},
    {1'b0,2'd0,19'h05555,8'hAA}, {1'b0,2'd0,19'h02AAA,8'h55},
    {1'b0,2'd0,19'h05555,8'h80}, {1'b0,2'd0,19'h05555,8'hAA},
    {1'b0,2'd0,19'h02AAA,8'h55}, {1'b0,2'd0,19'h01111,8'h10}
  };

  function automatic string ktag(input logic [1:0] k);
    case (k)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic int kdur(input logic [1:0] k);
    case (k)
      2'd0: return P_CYC;
      2'd1: return S_CYC;
      2'd2: return B_CYC;
      default: return C_CYC;
    endcase
  endfunction

  function automatic logic [AW-1:0] klo(input logic [1:0] k, input logic [AW-1:0] a);
    case (k)
      2'd0: return a;
      2'd1: return a & ~19'h00FFF;
      2'd2: return a & ~19'h0FFFF;
      default: return '0;
    endcase
  endfunction

  function automatic logic [AW-1:0] khi(input logic [1:0] k, input logic [AW-1:0] a);
    case (k)
      2'd0: return a;
      2'd1: return a | 19'h00FFF;
      2'd2: return a | 19'h0FFFF;
      default: return 19'h7FFFF;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] arr, output logic [7:0] v);
    rd_en = 1'b1; arr_rdata = arr;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid === 1'b1, "R9 rd_valid", rd_valid, 1);
    v = rd_data;
  endtask

  task automatic prog_seq(input logic [AW-1:0] a, input logic [7:0] d);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_seq(input logic [AW-1:0] a, input logic [7:0] code);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h80);
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(a, code);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0,     "R1 busy",     busy, 0);
    chk(op_req === 1'b0,   "R1 op_req",   op_req, 0);
    chk(rd_valid === 1'b0, "R1 rd_valid", rd_valid, 0);
    chk(rd_data === 8'h00, "R1 rd_data",  rd_data, 0);

    // Table walk: R2..R6, R7
    for (int i = 0; i < NV; i++) begin
      logic [29:0] e;
      e = VEC[i];
      wr(e[26:8], e[7:0]);
      chk(op_req === e[29], e[29] ? ktag(e[28:27]) : "R6 no request", op_req, e[29]);
      if (e[29]) begin
        chk(op_kind === e[28:27], ktag(e[28:27]), op_kind, e[28:27]);
        chk(op_lo === klo(e[28:27], e[26:8]), ktag(e[28:27]), op_lo, klo(e[28:27], e[26:8]));
        chk(op_hi === khi(e[28:27], e[26:8]), ktag(e[28:27]), op_hi, khi(e[28:27], e[26:8]));
        chk(op_data === ((e[28:27] == 2'd0) ? e[7:0] : 8'hFF), ktag(e[28:27]), op_data,
            (e[28:27] == 2'd0) ? e[7:0] : 8'hFF);
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
        chk(cnt == kdur(e[28:27]), "R7 busy length", cnt, kdur(e[28:27]));
      end
    end

    // R9: idle read
    rd(8'h5A, v);
    chk(v === 8'h5A, "R9 idle read", v, 8'h5A);

    // R10, R11, R12: program polling, data 3C (bit7 = 0)
    prog_seq(19'h00040, 8'h3C);
    rd(8'h3C, v); chk(v === 8'h80, "R10 R11 first status", v, 8'h80);
    rd(8'h3C, v); chk(v === 8'hC0, "R11 second status", v, 8'hC0);
    rd(8'h3C, v); chk(v === 8'h80, "R11 third status", v, 8'h80);
    wait_idle();
    rd(8'h3C, v); chk(v === 8'h3C, "R12 data after done", v, 8'h3C);
    rd(8'h3C, v); chk(v === 8'h3C, "R12 no toggle", v, 8'h3C);

    // R10, R11: erase polling, expected FFh so bit7 reads 0
    erase_seq(19'h01000, 8'h30);
    rd(8'h00, v); chk(v === 8'h00, "R10 erase status", v, 8'h00);
    rd(8'h00, v); chk(v === 8'h40, "R11 erase toggle", v, 8'h40);
    wait_idle();

    // R8: chip erase ignores every write, total length unchanged
    erase_seq(19'h05555, 8'h10);
    chk(op_kind === 2'd3, "R5 chip kind", op_kind, 3);
    cnt = 1;
    wr(19'h05555, 8'hAA); chk(op_req === 1'b0, "R8 ignored", op_req, 0); cnt++;
    wr(19'h02AAA, 8'h55); chk(op_req === 1'b0, "R8 ignored", op_req, 0); cnt++;
    wr(19'h05555, 8'hA0); chk(op_req === 1'b0, "R8 ignored", op_req, 0); cnt++;
    wr(19'h00010, 8'h12); chk(op_req === 1'b0, "R8 ignored", op_req, 0); cnt++;
    while (busy) begin cnt++; @(negedge clk); end
    chk(cnt == C_CYC + 1, "R8 R7 chip length", cnt - 1, C_CYC);
    wr(19'h05555, 8'hA0); chk(op_req === 1'b0, "R8 no kept progress", op_req, 0);
    wr(19'h00010, 8'h12); chk(op_req === 1'b0, "R8 no kept progress", op_req, 0);

    // Last busy cycle: an unlock write there is dropped (R8)
    prog_seq(19'h00200, 8'hF0);
    repeat (P_CYC - 1) @(negedge clk);
    chk(busy === 1'b1, "R7 last busy cycle", busy, 1);
    wr(19'h05555, 8'hAA);
    chk(busy === 1'b0, "R7 busy ended", busy, 0);
    wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0); wr(19'h00300, 8'h11);
    chk(op_req === 1'b0, "R8 last-cycle write dropped", op_req, 0);

    // Last busy cycle: a read there returns status (R10), the next returns data (R12)
    prog_seq(19'h00200, 8'hF0);
    repeat (P_CYC - 1) @(negedge clk);
    rd(8'hF0, v); chk(v === 8'h00, "R10 read in last busy cycle", v, 8'h00);
    rd(8'hF0, v); chk(v === 8'hF0, "R12 read after completion", v, 8'hF0);

    // R13: reset mid-operation
    erase_seq(19'h30000, 8'h50);
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy === 1'b0, "R13 busy cleared", busy, 0);
    rd(8'h6B, v); chk(v === 8'h6B, "R13 read array after reset", v, 8'h6B);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule